// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block answers an SPI master as a small serial EEPROM would, so that a controller that drives such a memory can be tested against it. It watches serial clock, serial data in and an active-low select, all sampled by its own system clock, and drives serial data out. An eight-bit status byte holds a busy flag, a write-enable flag and a two-bit protection field. A byte array sits behind it. The array takes a sixteen-bit address, of which only the low `ADDR_BITS` bits are used.

A transaction starts when select falls. The first byte is an opcode. Reads and writes then take a high and a low address byte. A write or a status write is only staged during the transaction. It is committed when select rises after the complete data byte, and that commit starts an internal cycle lasting `WR_CYCLES` system clocks. During that cycle the busy flag is set and the block answers only the status read. The controller walks through these states: IDLE (select high), CMD (opcode byte), ADDR_HI and ADDR_LO (address bytes), RD_DATA (streaming array bytes), STATUS (streaming the status byte), WR_DATA and SR_DATA (collecting the byte to stage), ARMED (waiting for select to rise) and SKIP (rest of an ignored transaction). Transitions:
- IDLE goes to CMD when select is low.
- From CMD, a completed opcode byte leads to STATUS, ADDR_HI, SR_DATA or SKIP.
- ADDR_HI goes to ADDR_LO.
- ADDR_LO goes to WR_DATA for a write or to RD_DATA for a read.
- WR_DATA and SR_DATA go to ARMED.
- Every state returns to IDLE when select rises.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and MISO is 0.
- R2: Opcode 0x06 sets the write-enable flag (status bit 1). Opcode 0x04 clears it.
- R3: Opcode 0x02 (write) and opcode 0x01 (status write) are ignored unless the write-enable flag is set. An ignored write leaves the array and the status unchanged.
- R4: Select rising after a full staged data byte starts an internal cycle of `WR_CYCLES` clocks. During the cycle status bit 0 reads 1. When the cycle ends, bits 0 and 1 both read 0.
- R5: Opcode 0x03 followed by two address bytes returns the addressed byte. Each further byte returns the next address, wrapping from the top of the array to 0.
- R6: The status write takes bits 3:2 of its data byte into status bits 3:2. Status bits 7:4 always read 0.
- R7: A protection value of 1 guards the top quarter of the array, 2 the top half and 3 all of it. A write to a guarded address is discarded, starts no cycle and leaves the write-enable flag set.
- R8: While the busy flag is set, every opcode except 0x05 is ignored, and MISO returns 0x00 for the rest of that transaction.
- R9: If select rises before all 8 bits of the data byte have arrived, the write is abandoned and no cycle starts.
- R10: MISO is 0 whenever select is high.
- R11: An undefined opcode is ignored and MISO returns 0x00 for the rest of the transaction.
- R12: Opcode 0x05 returns the status byte in every byte that follows the opcode. Data is taken on rising SCK and MISO changes on falling SCK (SPI mode 3), most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master, idle high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the master, 0 while deselected |

## Verification
Each SPI pin passes through `SYNC_STAGES` flops and an edge register. A falling SCK therefore reaches MISO about three system clocks later. The bench holds each SCK half period for six clocks and samples MISO just before raising SCK. The internal cycle begins about three clocks after select rises. The bench reads the status immediately afterwards, well within the `WR_CYCLES` window, so it still sees the busy flag. It then polls the status until the flag drops before it checks that the write-enable flag has cleared. Ignored and protected writes are checked by reading the status and the array back through later transactions.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_SR_DATA,
        ST_STATUS,
        ST_ARMED,
        ST_SKIP
    } ee_state_e;

    // Guarded region from the two protection bits and the top two address bits
    function automatic logic region_locked(input logic [1:0] prot, input logic [1:0] top);
        logic hit;
        unique case (prot)
            2'd0:    hit = 1'b0;
            2'd1:    hit = (top == 2'b11);
            2'd2:    hit = top[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic mosi_s,
    output logic cs_n_s
);

    logic [STAGES-1:0] sck_pipe, mosi_pipe, cs_pipe;
    logic              sck_d, cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_pipe  <= '1;
            mosi_pipe <= '0;
            cs_pipe   <= '1;
            sck_d     <= 1'b1;
            cs_d      <= 1'b1;
        end else begin
            sck_pipe  <= {sck_pipe[STAGES-2:0], sck};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
            sck_d     <= sck_pipe[STAGES-1];
            cs_d      <= cs_pipe[STAGES-1];
        end
    end

    assign mosi_s   = mosi_pipe[STAGES-1];
    assign cs_n_s   = cs_pipe[STAGES-1];
    assign sck_rise = sck_pipe[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_pipe[STAGES-1] & sck_d;
    assign cs_rise  = cs_pipe[STAGES-1] & ~cs_d;

endmodule

// File: rtl/spi_wr_timer.sv
module spi_wr_timer #(
    parameter int CYCLES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int ADDR_BITS = 4,
    parameter int DW        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [DW-1:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS   = 4,
    parameter int WR_CYCLES   = 1600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic spi_cs_n,
    output logic spi_miso
);

    logic sck_rise, sck_fall, cs_rise, mosi_s, cs_n_s;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .mosi_s   (mosi_s),
        .cs_n_s   (cs_n_s)
    );

    ee_state_e            state_q, state_d;
    logic [2:0]           bit_cnt;
    logic [6:0]           rx_sh;
    logic [7:0]           rx_byte;
    logic                 byte_done;
    logic                 wel, busy, wr_done, cyc_start;
    logic [1:0]           prot, pend_prot;
    logic [ADDR_BITS-1:0] addr, rd_addr;
    logic [7:0]           pend_data, tx_word, rd_data, status;
    logic                 op_is_sr, op_is_wr, miso_q;
    logic                 commit_ok, sr_commit, mem_we;

    assign rx_byte   = {rx_sh, mosi_s};
    assign byte_done = sck_rise & ~cs_n_s & (bit_cnt == 3'd7);
    assign status    = {4'b0000, prot, wel, busy};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        if (busy && rx_byte != OP_RDSR)       state_d = ST_SKIP;
                        else if (rx_byte == OP_RDSR)          state_d = ST_STATUS;
                        else if (rx_byte == OP_READ)          state_d = ST_ADDR_HI;
                        else if (rx_byte == OP_WRITE && wel)  state_d = ST_ADDR_HI;
                        else if (rx_byte == OP_WRSR && wel)   state_d = ST_SR_DATA;
                        else                                  state_d = ST_SKIP;
                    end
                end
                ST_ADDR_HI: if (byte_done) state_d = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done) state_d = op_is_wr ? ST_WR_DATA : ST_RD_DATA;
                ST_WR_DATA: if (byte_done) state_d = ST_ARMED;
                ST_SR_DATA: if (byte_done) state_d = ST_ARMED;
                default:    state_d = state_q;
            endcase
        end
    end

    // ---------------- serial datapath ----------------
    assign rd_addr = (state_q == ST_ADDR_LO) ? rx_byte[ADDR_BITS-1:0] : addr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_word   <= '0;
            miso_q    <= 1'b0;
            addr      <= '0;
            pend_data <= '0;
            pend_prot <= '0;
            op_is_sr  <= 1'b0;
            op_is_wr  <= 1'b0;
        end else if (cs_n_s) begin
            bit_cnt <= '0;
            tx_word <= '0;
            miso_q  <= 1'b0;
        end else begin
            if (sck_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sh   <= rx_byte[6:0];
            end
            if (sck_fall) begin
                miso_q <= tx_word[3'd7 - bit_cnt];
            end
            if (byte_done) begin
                tx_word <= 8'h00;
                case (state_q)
                    ST_CMD: begin
                        if (!busy || rx_byte == OP_RDSR) begin
                            op_is_sr <= (rx_byte == OP_WRSR);
                            op_is_wr <= (rx_byte == OP_WRITE);
                            if (rx_byte == OP_RDSR) tx_word <= status;
                        end
                    end
                    ST_ADDR_LO: begin
                        addr <= rx_byte[ADDR_BITS-1:0];
                        if (!op_is_wr) tx_word <= rd_data;
                    end
                    ST_RD_DATA: begin
                        addr    <= rd_addr;
                        tx_word <= rd_data;
                    end
                    ST_STATUS:  tx_word   <= status;
                    ST_WR_DATA: pend_data <= rx_byte;
                    ST_SR_DATA: pend_prot <= rx_byte[3:2];
                    default:    ;
                endcase
            end
        end
    end

    assign spi_miso = spi_cs_n ? 1'b0 : miso_q;

    // ---------------- commit at select rising ----------------
    assign commit_ok = cs_rise & (state_q == ST_ARMED);
    assign sr_commit = commit_ok & op_is_sr;
    assign mem_we    = commit_ok & ~op_is_sr & ~region_locked(prot, addr[ADDR_BITS-1 -: 2]);
    assign cyc_start = sr_commit | mem_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            prot <= 2'b00;
        end else begin
            if (wr_done) begin
                wel <= 1'b0;
            end else if (byte_done && state_q == ST_CMD && !busy) begin
                if (rx_byte == OP_WREN)      wel <= 1'b1;
                else if (rx_byte == OP_WRDI) wel <= 1'b0;
            end
            if (sr_commit) prot <= pend_prot;
        end
    end

    spi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .busy  (busy),
        .done  (wr_done)
    );

    spi_ee_array #(.ADDR_BITS(ADDR_BITS), .DW(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr),
        .wdata (pend_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R3
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) cyc_start |-> wel);
    // R7
    full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !op_is_sr) |-> (prot != 2'b11));
    // R4
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel);
    // R8
    busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state_q == ST_CMD && busy && rx_byte != OP_RDSR)
        |=> (state_q == ST_SKIP || state_q == ST_IDLE));
    // R6
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot != $past(prot)) |-> busy);

endmodule

// File: tb/spi_eeprom_slave_tb.sv
`timescale 1ns/1ps
module spi_eeprom_slave_tb;

    localparam int AB   = 4;
    localparam int WRC  = 1600;
    localparam int HALF = 6;
    localparam int N    = 1 << AB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b1, mosi = 1'b0, cs_n = 1'b1;
    logic miso;

    always #2 clk = ~clk;

    spi_eeprom_slave #(.ADDR_BITS(AB), .WR_CYCLES(WRC), .SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (sck),
        .spi_mosi (mosi),
        .spi_cs_n (cs_n),
        .spi_miso (miso)
    );

    int checks = 0, fails = 0;
    logic [7:0] model [N];
    bit finished = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        ticks(1);
        cs_n = 1'b0;
        ticks(HALF);
    endtask

    task automatic desel();
        ticks(HALF);
        cs_n = 1'b1;
        ticks(4 * HALF);
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            sck = 1'b0;
            mosi = tx[i];
            ticks(HALF);
            rx[i] = miso;
            sck = 1'b1;
            ticks(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        shift_bits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
    endtask

    task automatic wr_byte(input int a, input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'(a), d); xfer(v, d); desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 200; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic read_check(input int a, input int n, input string tag);
        logic [7:0] d;
        sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'(a), d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            check(tag, d, model[(a + k) % N]);
        end
        desel();
        check("R10 miso low after deselect", {7'b0, miso}, 8'h00);
    endtask

    function automatic bit locked(input int p, input int a);
        return (p == 3) || (p == 2 && a >= N / 2) || (p == 1 && a >= 3 * N / 4);
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        ticks(195000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [7:0] s, d, v;
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        ticks(5);
        rst_n = 1'b1;
        ticks(5);

        // R1 / R10: reset state
        check("R10 miso low while deselected", {7'b0, miso}, 8'h00);
        rdsr(s);
        check("R1 status after reset", s, 8'h00);

        // R2: set and clear the enable flag
        cmd1(8'h06); rdsr(s); check("R2 enable set", s, 8'h02);
        cmd1(8'h04); rdsr(s); check("R2 enable cleared", s, 8'h00);

        // R3: write without the enable flag
        wr_byte(3, 8'h11); rdsr(s); check("R3 no cycle without enable", s, 8'h00);
        read_check(3, 1, "R1 erased value kept R3");

        // R4 / R8: write sweep over every address
        for (int a = 0; a < N; a++) begin
            v = 8'((a * 37 + 5) & 8'hFF);
            cmd1(8'h06);
            wr_byte(a, v);
            model[a] = v;
            rdsr(s); check("R4 busy after select rise", s, 8'h03);
            if (a == 0) begin
                sel(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d); desel();
                check("R8 read ignored while busy", d, 8'h00);
                cmd1(8'h04);
                rdsr(s); check("R8 disable ignored while busy", s, 8'h03);
            end
            wait_idle();
            rdsr(s); check("R4 flags cleared after cycle", s, 8'h00);
        end

        // R5: sequential read with wrap
        read_check(0, N + 1, "R5 sequential read");
        read_check(N - 2, 4, "R5 wrap read");

        // R9: select rises inside the data byte
        cmd1(8'h06);
        sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h05, d); shift_bits(8'hC3, 4, d); desel();
        rdsr(s); check("R9 aborted write starts no cycle", s, 8'h02);
        read_check(5, 1, "R9 aborted write leaves data");
        cmd1(8'h04);

        // R11: undefined opcode
        sel(); xfer(8'hAB, d); xfer(8'h00, d); desel();
        check("R11 undefined opcode returns zero", d, 8'h00);
        rdsr(s); check("R11 status unchanged", s, 8'h00);

        // R12: status repeats for every byte
        cmd1(8'h06);
        sel(); xfer(8'h05, d); xfer(8'h00, d); xfer(8'h00, s); desel();
        check("R12 status first byte", d, 8'h02);
        check("R12 status repeated", s, 8'h02);
        cmd1(8'h04);

        // R6: status write without the enable flag
        sel(); xfer(8'h01, d); xfer(8'h0C, d); desel();
        rdsr(s); check("R6 status write needs enable", s, 8'h00);

        // R6 / R7: protection levels
        for (int p = 1; p < 4; p++) begin
            cmd1(8'h06);
            sel(); xfer(8'h01, d); xfer(8'((p << 2) | 8'hF3), d); desel();
            wait_idle();
            rdsr(s); check("R6 protection bits", s, 8'(p << 2));
            for (int a = 0; a < N; a++) begin
                v = 8'((a * 91 + p * 13) & 8'hFF);
                cmd1(8'h06);
                wr_byte(a, v);
                if (locked(p, a)) begin
                    rdsr(s); check("R7 guarded write discarded", s, 8'((p << 2) | 2));
                end else begin
                    model[a] = v;
                    wait_idle();
                end
            end
            cmd1(8'h04);
            read_check(0, N, "R7 array after guarded sweep");
        end

        report();
    end

endmodule